// File: doc/BRIEF.md
# 31-Bit Frame Serializer for Byte Streams

This block turns a stream of 8-bit words into a serial bit stream for a chain of pixel driver shift registers. Each pixel frame is 31 bits long. The block pulses a latch strobe right after the 31st bit of every frame. Because the frame length is not a multiple of the byte width, that boundary usually falls inside a byte. The bits of that byte that follow the boundary go on to start the next frame. The carry-over grows by one bit per frame: the first frame needs four bytes, and the later frames latch one bit earlier each time within their final byte.

Bytes enter through a valid/ready handshake. Bits leave MSB first on a serial data line with its own serial clock. The receiver samples the data on the rising edge of that clock, and one serial period takes two system cycles. A frame-release input paces the frames, and so sets how fast data moves down the driver chain.

The block never starts shifting the byte that completes the current frame until release has been seen. This stops the drivers' shift registers from being overrun when the frame rate is slow. A single release pulse is remembered until it is used. Tying release high gives free-running frames.

Top module: `pfs_serializer`

## Requirements
- R1: After a synchronous reset, ser_clk_o and frame_latch_o are low and byte_ready_o is high. The frame and byte bit counters are cleared, so the first latch follows the 31st bit of the data sent after reset.
- R2: Each accepted byte is sent MSB first. A bit appears on ser_data_o one system cycle before ser_clk_o goes high. ser_clk_o stays high for exactly one cycle, and ser_data_o is unchanged at its rising edge.
- R3: frame_latch_o rises after exactly 31 rising edges of ser_clk_o since reset or since the previous latch, and before the next rising edge. This holds even when the boundary lies inside a byte.
- R4: The latch stays high for exactly two system cycles, one serial period, with ser_clk_o low. Afterwards the bits left in the same byte continue as the next frame.
- R5: byte_ready_o is high only while no byte is held. A byte is taken on a cycle with byte_valid_i and byte_ready_o both high. byte_ready_o then stays low until all 8 bits are shifted: 16 cycles, plus 2 if a latch falls inside the byte, plus any release wait.
- R6: A byte accepted when 23 or more bits of the current frame are already out completes that frame. That byte is not shifted, and ser_clk_o stays low, until release is available. Frame k (counting from 0) starts with a carry of 8*ceil(31k/8)-31k bits. It therefore stalls after carry plus enough whole bytes to reach at least 23 bits: 24, 25, 26, ... bits.
- R7: A one-cycle pulse on frame_release_i is stored, even if it comes before the frame reaches its stall point. Each stored pulse releases exactly one frame.
- R8: With frame_release_i held high, frames run without stalls. After 8N bits, floor(8N/31) latches have occurred and 8N mod 31 bits of the next frame are out.
- R9: A reset in the middle of a frame discards the partial frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_data_i | input | 8 | Byte to serialize, MSB shifted first |
| byte_valid_i | input | 1 | byte_data_i holds a byte |
| byte_ready_o | output | 1 | Block can take a byte this cycle |
| frame_release_i | input | 1 | Permits the next frame to complete (level or pulse) |
| ser_clk_o | output | 1 | Serial clock to the driver chain |
| ser_data_o | output | 1 | Serial data, valid at the rising edge of ser_clk_o |
| frame_latch_o | output | 1 | Frame latch strobe, two cycles long |

## Verification
In free-running mode the block gets a burst of bytes starting with all-ones and all-zeros, followed by random bytes with random valid gaps. Every bit is compared against the sent stream, and every latch position against the 31-bit count, which shows whether the latch lands at the correct point inside the straddling byte. The readiness time of each byte shows whether a latch was inserted inside it. In held-release mode the first pulse is sent early and the later pulses are sent while the block is stalled. This separates a stored pulse from a live one and confirms the stall points at 25 and 26 bits, which shows the carry growing by one bit per frame. A reset in the middle of a frame, followed by a fresh stream, shows that the bit counters really restart.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_HOLD  = 3'd1,
    S_LO    = 3'd2,
    S_HI    = 3'd3,
    S_LAT_A = 3'd4,
    S_LAT_B = 3'd5
  } pfs_state_t;

endpackage

// File: rtl/pfs_byte_buf.sv
module pfs_byte_buf #(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_i,
  input  logic [BYTE_BITS-1:0] din_i,
  input  logic                 shift_i,
  output logic                 msb_o
);

  logic [BYTE_BITS-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (load_i) begin
      word_q <= din_i;
    end else if (shift_i) begin
      word_q <= {word_q[BYTE_BITS-2:0], 1'b0};
    end
  end

  assign msb_o = word_q[BYTE_BITS-1];

endmodule

// File: rtl/pfs_frame_ctrl.sv
module pfs_frame_ctrl
  import pfs_pkg::*;
#(
  parameter int FRAME_BITS = 31,
  parameter int BYTE_BITS  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  input  logic release_i,
  output logic ready_o,
  output logic load_o,
  output logic shift_o,
  output logic sclk_d_o,
  output logic latch_d_o
);

  localparam int FW        = $clog2(FRAME_BITS);
  localparam int BW        = $clog2(BYTE_BITS);
  localparam int HOLD_FROM = FRAME_BITS - BYTE_BITS;

  pfs_state_t    state_q, state_d;
  logic [FW-1:0] fpos_q;
  logic [BW-1:0] bpos_q;
  logic          pend_q;

  logic go, straddle, accept, use_rel, last_fbit, last_bbit;

  assign go        = pend_q | release_i;
  assign straddle  = fpos_q >= FW'(HOLD_FROM);
  assign accept    = (state_q == S_IDLE) && valid_i;
  assign last_fbit = fpos_q == FW'(FRAME_BITS - 1);
  assign last_bbit = bpos_q == BW'(BYTE_BITS - 1);
  assign use_rel   = go && ((accept && straddle) || (state_q == S_HOLD));

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (valid_i) state_d = (straddle && !go) ? S_HOLD : S_LO;
      S_HOLD:  if (go) state_d = S_LO;
      S_LO:    state_d = S_HI;
      S_HI: begin
        if (last_fbit)      state_d = S_LAT_A;
        else if (last_bbit) state_d = S_IDLE;
        else                state_d = S_LO;
      end
      S_LAT_A: state_d = S_LAT_B;
      S_LAT_B: state_d = (bpos_q == '0) ? S_IDLE : S_LO;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      fpos_q  <= '0;
      bpos_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= use_rel ? 1'b0 : (pend_q | release_i);
      if (state_q == S_HI) begin
        fpos_q <= last_fbit ? '0 : fpos_q + FW'(1);
        bpos_q <= last_bbit ? '0 : bpos_q + BW'(1);
      end
    end
  end

  assign ready_o   = (state_q == S_IDLE);
  assign load_o    = accept;
  assign shift_o   = (state_q == S_HI);
  assign sclk_d_o  = (state_q == S_HI);
  assign latch_d_o = (state_q == S_LAT_A) || (state_q == S_LAT_B);

endmodule

// File: rtl/pfs_serializer.sv
module pfs_serializer #(
  parameter int FRAME_BITS = 31,
  parameter int BYTE_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [BYTE_BITS-1:0] byte_data_i,
  input  logic                 byte_valid_i,
  output logic                 byte_ready_o,
  input  logic                 frame_release_i,
  output logic                 ser_clk_o,
  output logic                 ser_data_o,
  output logic                 frame_latch_o
);

  logic load, shift, sclk_d, latch_d, msb;

  pfs_frame_ctrl #(
    .FRAME_BITS(FRAME_BITS),
    .BYTE_BITS (BYTE_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .valid_i  (byte_valid_i),
    .release_i(frame_release_i),
    .ready_o  (byte_ready_o),
    .load_o   (load),
    .shift_o  (shift),
    .sclk_d_o (sclk_d),
    .latch_d_o(latch_d)
  );

  pfs_byte_buf #(
    .BYTE_BITS(BYTE_BITS)
  ) u_buf (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .din_i  (byte_data_i),
    .shift_i(shift),
    .msb_o  (msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_clk_o     <= 1'b0;
      ser_data_o    <= 1'b0;
      frame_latch_o <= 1'b0;
    end else begin
      ser_clk_o     <= sclk_d;
      ser_data_o    <= msb;
      frame_latch_o <= latch_d;
    end
  end

endmodule

// File: rtl/pfs_serializer_chk.sv
module pfs_serializer_chk #(
  parameter int FRAME_BITS = 31
) (
  input logic clk,
  input logic rst,
  input logic byte_valid_i,
  input logic byte_ready_o,
  input logic ser_clk_o,
  input logic ser_data_o,
  input logic frame_latch_o
);

  logic [7:0] cnt_q;
  logic       sclk_q, latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      sclk_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sclk_q  <= ser_clk_o;
      latch_q <= frame_latch_o;
      if (frame_latch_o && !latch_q) cnt_q <= '0;
      else if (ser_clk_o && !sclk_q) cnt_q <= cnt_q + 8'd1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $fell(rst) |-> (!ser_clk_o && !frame_latch_o && byte_ready_o));

  assert_sclk_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    ser_clk_o |=> !ser_clk_o);

  assert_data_stable_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk_o) |-> $stable(ser_data_o));

  assert_latch_at_frame_end_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_latch_o) |-> (cnt_q == 8'(FRAME_BITS)));

  assert_no_overrun_R3: assert property (@(posedge clk) disable iff (rst)
    (ser_clk_o && !sclk_q) |-> (cnt_q < 8'(FRAME_BITS)));

  assert_latch_sclk_low_R4: assert property (@(posedge clk) disable iff (rst)
    frame_latch_o |-> !ser_clk_o);

  assert_latch_two_cycles_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_latch_o) |=> frame_latch_o);

  assert_latch_ends_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_latch_o && latch_q) |=> !frame_latch_o);

  assert_ready_drops_R5: assert property (@(posedge clk) disable iff (rst)
    (byte_ready_o && byte_valid_i) |=> !byte_ready_o);

endmodule

bind pfs_serializer pfs_serializer_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .byte_valid_i (byte_valid_i),
  .byte_ready_o (byte_ready_o),
  .ser_clk_o    (ser_clk_o),
  .ser_data_o   (ser_data_o),
  .frame_latch_o(frame_latch_o)
);

// File: tb/pfs_serializer_bench.sv
`timescale 1ns/1ps
module pfs_serializer_bench;

  localparam int FRAME = 31;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] byte_data = '0;
  logic       byte_valid = 1'b0;
  logic       byte_ready;
  logic       rel = 1'b0;
  logic       sclk, sdo, latch;

  int total = 0;
  int bad = 0;

  bit exp_q[$];
  int since_latch = 0;
  int latches = 0;
  int lat_w = 0;
  logic prev_sclk = 1'b0;
  logic prev_latch = 1'b0;

  always #4 clk = ~clk;

  pfs_serializer u_pfs_serializer (
    .clk            (clk),
    .rst            (rst),
    .byte_data_i    (byte_data),
    .byte_valid_i   (byte_valid),
    .byte_ready_o   (byte_ready),
    .frame_release_i(rel),
    .ser_clk_o      (sclk),
    .ser_data_o     (sdo),
    .frame_latch_o  (latch)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int stall_pos(input int k);
    int carry, p;
    carry = 8 * ((FRAME * k + 7) / 8) - FRAME * k;
    p = carry;
    while (p < FRAME - 8) p += 8;
    return p;
  endfunction

  // Monitor: samples the outputs at the falling edge of clk.
  always @(negedge clk) begin
    if (rst) begin
      exp_q.delete();
      since_latch = 0;
      latches = 0;
      lat_w = 0;
      prev_sclk = 1'b0;
      prev_latch = 1'b0;
    end else begin
      if (sclk && !prev_sclk) begin
        bit e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
        chk(sdo == e, "R2", "serial bit", int'(sdo), int'(e));
        chk(since_latch < FRAME, "R3", "bits before latch", since_latch + 1, FRAME);
        since_latch++;
      end
      if (sclk && prev_sclk) chk(1'b0, "R2", "sclk high width", 2, 1);
      if (latch) begin
        lat_w++;
        if (sclk) chk(1'b0, "R4", "sclk during latch", 1, 0);
      end
      if (latch && !prev_latch) begin
        chk(since_latch == FRAME, "R3", "latch position", since_latch, FRAME);
        latches++;
        since_latch = 0;
      end
      if (!latch && prev_latch) begin
        chk(lat_w == 2, "R4", "latch width", lat_w, 2);
        lat_w = 0;
      end
      prev_sclk = sclk;
      prev_latch = latch;
    end
  end

  // Called at a falling edge. Returns the number of cycles ready stayed low.
  task automatic send_byte(input logic [7:0] b, output int low);
    bit acc;
    byte_valid = 1'b1;
    byte_data = b;
    do begin
      acc = byte_ready;
      @(negedge clk);
    end while (!acc);
    byte_valid = 1'b0;
    for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
    low = 0;
    while (!byte_ready) begin
      low++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  bit feeder_done;

  initial begin
    int low, l0;
    void'($urandom(32'h00c0ffee));

    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0, "R1", "ser_clk after reset", int'(sclk), 0);
    chk(latch == 1'b0, "R1", "latch after reset", int'(latch), 0);
    chk(byte_ready == 1'b1, "R1", "ready after reset", int'(byte_ready), 1);

    // R8 / R5: free-running frames with corner bytes, then random bytes and gaps
    rel = 1'b1;
    for (int n = 0; n < 40; n++) begin
      logic [7:0] b;
      b = (n == 0) ? 8'hFF : (n == 1) ? 8'h00 : 8'($urandom);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      l0 = latches;
      send_byte(b, low);
      chk(low == 16 + 2 * (latches - l0), "R5", "ready low cycles", low,
          16 + 2 * (latches - l0));
    end
    repeat (10) @(negedge clk);
    chk(latches == 10, "R8", "free-run latch count", latches, 10);
    chk(since_latch == 10, "R8", "free-run trailing bits", since_latch, 10);

    // R6 / R7: held release with an early stored pulse
    rel = 1'b0;
    do_reset();
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
    feeder_done = 1'b0;
    fork
      begin
        int lw;
        for (int n = 0; n < 12; n++) send_byte(8'($urandom), lw);
        feeder_done = 1'b1;
      end
    join_none
    repeat (300) @(negedge clk);
    chk(latches == 1, "R7", "early pulse released frame 0", latches, 1);
    chk(since_latch == stall_pos(1), "R6", "frame 1 stall point", since_latch, stall_pos(1));
    chk(byte_ready == 1'b0, "R6", "straddling byte held", int'(byte_ready), 0);
    repeat (100) @(negedge clk);
    chk(latches == 1 && since_latch == stall_pos(1), "R7", "one pulse one frame",
        since_latch, stall_pos(1));
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
    repeat (300) @(negedge clk);
    chk(latches == 2, "R6", "frame 1 latched after release", latches, 2);
    chk(since_latch == stall_pos(2), "R6", "frame 2 stall point", since_latch, stall_pos(2));
    rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
    repeat (300) @(negedge clk);
    chk(latches == 3, "R7", "third pulse latch count", latches, 3);
    chk(since_latch == 3, "R6", "carry after frame 2", since_latch, 3);
    chk(feeder_done && byte_ready, "R5", "all bytes taken", int'(feeder_done), 1);

    // R9: reset in the middle of a frame
    rel = 1'b1;
    do_reset();
    send_byte(8'hA5, low);
    send_byte(8'h3C, low);
    repeat (20) @(negedge clk);
    chk(since_latch == 16 && latches == 0, "R9", "partial frame before reset",
        since_latch, 16);
    do_reset();
    chk(byte_ready == 1'b1 && sclk == 1'b0, "R1", "state after mid-frame reset",
        int'(byte_ready), 1);
    for (int n = 0; n < 4; n++) send_byte(8'($urandom), low);
    repeat (10) @(negedge clk);
    chk(latches == 1, "R9", "latch count after fresh stream", latches, 1);
    chk(since_latch == 1, "R9", "carry after fresh frame", since_latch, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule